// File: doc/BRIEF.md
# Flash Erase-Block Lock State Manager

This block holds the protection state of every erase block in a flash array and decides whether a program or erase aimed at a given block may proceed. Software issues lock, unlock and lock-down requests that name a block by index. An active-low write-protect pin sets how strict the lock-down mark is. An active-low reset/power-down pin returns every block to the locked state.

Each block keeps two bits: a lock bit and a sticky lock-down mark. While write-protect is low, a marked block is frozen and no software unlock can open it. While write-protect is high, a marked block acts as an ordinary locked block, and software may open it and close it again. The mark stays in place throughout. When the pin drops again, every marked block is relocked and frozen. A combinational query port gives the effective state of any block and a write-permitted flag. A one-cycle pulse tells the surrounding device to return to read-array mode when reset is released.

Top module: `flash_lock_manager`

## Requirements
- R1: While `rst_pin_n` is low, every queried block reports state 2'b01 (locked) and `qry_write_ok` is 0. Requests are ignored and all lock-down marks are cleared.
- R2: `read_mode_pulse` is high for exactly one cycle, after the first rising clock edge at which `rst_pin_n` is sampled high. Every block is locked at that point.
- R3: Requests are presented with `req_valid` high and `req_op` set to 2'b01 for lock, 2'b10 for unlock, 2'b11 for lock-down, or 2'b00 for no operation. The effect shows on the query port after the next rising edge.
- R4: A lock-down request sets both the lock bit and the mark. While `wp_n` is low, such a block reports state 2'b11 and cannot be written.
- R5: While `wp_n` is low, an unlock request to a marked block is refused and leaves the block at state 2'b11. An unmarked block unlocks normally.
- R6: While `wp_n` is high, a marked block reports 2'b01. Unlock and lock requests then move it between 2'b00 and 2'b01.
- R7: On a falling edge of `wp_n`, every marked block is relocked and reports 2'b11, even if software unlocked it while the pin was high.
- R8: `qry_write_ok` is 1 only when the queried block reports state 2'b00 and the device has left reset.
- R9: A request whose index is NUM_BLOCKS or more changes no block and raises `req_err` for one cycle, after the next edge. A query with such an index reports 2'b01 with `qry_write_ok` 0.
- R10: When a request arrives in the same cycle as a falling edge of `wp_n`, the edge is applied first. An unlock of a marked block in that cycle is therefore refused.
- R11: Only reset clears a lock-down mark. The mark persists while `wp_n` is high, and after reset a formerly marked block unlocks freely with `wp_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset/power-down, sampled on the clock |
| wp_n | input | 1 | Active-low write-protect level |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Request kind: 00 none, 01 lock, 10 unlock, 11 lock-down |
| req_idx | input | IDX_W | Target block index of the request |
| qry_idx | input | IDX_W | Block index to query |
| qry_state | output | 2 | Effective state: 00 unlocked, 01 locked, 11 locked-down |
| qry_write_ok | output | 1 | Program/erase permitted on the queried block |
| read_mode_pulse | output | 1 | One-cycle pulse on leaving reset |
| req_err | output | 1 | One-cycle pulse for an out-of-range request index |

## Verification
The assertions assume that `rst_pin_n` is held low for at least one clock before any property is evaluated. They also assume that `wp_n` and the request inputs are stable around each rising edge, because all of them are sampled as synchronous levels. The bench drives every input one time unit after a rising edge and reads the outputs before the next edge. It also starts with reset held low for several cycles, so the write-protect history register and the per-block state are defined before the first property leaves its disabled state.

// File: rtl/flm_pkg.sv
package flm_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_LOCK     = 2'b01,
    OP_UNLOCK   = 2'b10,
    OP_LOCKDOWN = 2'b11
  } lk_op_e;

  typedef enum logic [1:0] {
    ST_OPEN   = 2'b00,
    ST_LOCKED = 2'b01,
    ST_RSVD   = 2'b10,
    ST_FROZEN = 2'b11
  } lk_state_e;

  // Effective state seen by the outside world.
  function automatic lk_state_e state_code(input logic lock, input logic mark,
                                           input logic wp_high);
    if (mark && !wp_high) return ST_FROZEN;
    else if (lock)        return ST_LOCKED;
    else                  return ST_OPEN;
  endfunction

  // A software unlock only succeeds when the mark is absent or the pin is high.
  function automatic logic unlock_allowed(input logic mark, input logic wp_high);
    return !mark || wp_high;
  endfunction

endpackage

// File: rtl/flm_pin_tracker.sv
module flm_pin_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  output logic wp_q,
  output logic wp_fall,
  output logic in_service,
  output logic read_pulse
);

  always_ff @(posedge clk) begin
    wp_q       <= wp_n;
    in_service <= rst_n;
    read_pulse <= rst_n & ~in_service;
  end

  // Falling edge of write-protect as seen at the coming clock edge.
  assign wp_fall = wp_q & ~wp_n;

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    read_pulse |=> !read_pulse);

  p_pulse_on_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_service) |-> read_pulse);

endmodule

// File: rtl/flm_block_cell.sv
module flm_block_cell
  import flm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wp_fall,
  input  logic   wp_high,
  input  logic   hit,
  input  lk_op_e op,
  output logic   lock_q,
  output logic   mark_q
);

  logic lock_d, mark_d;

  // Write-protect edge first, then the request.
  always_comb begin
    lock_d = lock_q | (wp_fall & mark_q);
    mark_d = mark_q;
    if (hit) begin
      case (op)
        OP_LOCK:     lock_d = 1'b1;
        OP_LOCKDOWN: begin
          lock_d = 1'b1;
          mark_d = 1'b1;
        end
        OP_UNLOCK:   if (unlock_allowed(mark_q, wp_high)) lock_d = 1'b0;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      mark_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      mark_q <= mark_d;
    end
  end

  p_mark_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |=> mark_q);

  p_fall_relocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_fall && mark_q) |=> lock_q);

  p_unlock_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_UNLOCK && mark_q && !wp_high) |=> lock_q);

  p_lockdown_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_LOCKDOWN) |=> (lock_q && mark_q));

endmodule

// File: rtl/flm_query_mux.sv
module flm_query_mux
  import flm_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BLOCKS-1:0] lock_vec,
  input  logic [NUM_BLOCKS-1:0] mark_vec,
  input  logic                  wp_q,
  input  logic                  in_service,
  input  logic [IDX_W-1:0]      qry_idx,
  output logic [1:0]            qry_state,
  output logic                  qry_write_ok
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLOCKS);

  logic      in_range;
  logic      sel_lock, sel_mark;
  lk_state_e st;

  assign in_range = {1'b0, qry_idx} < LIMIT;

  always_comb begin
    sel_lock = 1'b1;
    sel_mark = 1'b0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (qry_idx == IDX_W'(i)) begin
        sel_lock = lock_vec[i];
        sel_mark = mark_vec[i];
      end
    end
  end

  assign st           = in_range ? state_code(sel_lock, sel_mark, wp_q) : ST_LOCKED;
  assign qry_state    = st;
  assign qry_write_ok = in_range && !sel_lock && in_service;

  p_frozen_is_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && sel_mark && !wp_q) |-> sel_lock);

  p_no_rsvd_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    qry_state != ST_RSVD);

endmodule

// File: rtl/flash_lock_manager.sv
module flash_lock_manager
  import flm_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             wp_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [1:0]       qry_state,
  output logic             qry_write_ok,
  output logic             read_mode_pulse,
  output logic             req_err
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLOCKS);

  lk_op_e                op;
  logic                  req_in_range;
  logic                  req_active;
  logic                  wp_q, wp_fall, in_service;
  logic [NUM_BLOCKS-1:0] hit;
  logic [NUM_BLOCKS-1:0] lock_vec, mark_vec;

  assign op           = lk_op_e'(req_op);
  assign req_in_range = {1'b0, req_idx} < LIMIT;
  assign req_active   = req_valid && (op != OP_NONE);

  flm_pin_tracker u_pins (
    .clk        (clk),
    .rst_n      (rst_pin_n),
    .wp_n       (wp_n),
    .wp_q       (wp_q),
    .wp_fall    (wp_fall),
    .in_service (in_service),
    .read_pulse (read_mode_pulse)
  );

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_cell
    assign hit[g] = req_active && req_in_range && (req_idx == IDX_W'(g));

    flm_block_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_pin_n),
      .wp_fall (wp_fall),
      .wp_high (wp_n),
      .hit     (hit[g]),
      .op      (op),
      .lock_q  (lock_vec[g]),
      .mark_q  (mark_vec[g])
    );
  end

  flm_query_mux #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_query (
    .clk          (clk),
    .rst_n        (rst_pin_n),
    .lock_vec     (lock_vec),
    .mark_vec     (mark_vec),
    .wp_q         (wp_q),
    .in_service   (in_service),
    .qry_idx      (qry_idx),
    .qry_state    (qry_state),
    .qry_write_ok (qry_write_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_pin_n) req_err <= 1'b0;
    else            req_err <= req_active && !req_in_range;
  end

  p_err_on_bad_idx_r9: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (req_active && !req_in_range) |=> req_err);

  p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $onehot0(hit));

  p_write_needs_open_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    qry_write_ok |-> (qry_state == 2'b00));

endmodule

// File: tb/flash_lock_manager_test.sv
module flash_lock_manager_test;

  localparam int NB = 12;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_pin_n, wp_n, req_valid;
  logic [1:0]    req_op;
  logic [IW-1:0] req_idx, qry_idx;
  logic [1:0]    qry_state;
  logic          qry_write_ok, read_mode_pulse, req_err;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  flash_lock_manager #(.NUM_BLOCKS(NB), .IDX_W(IW)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .wp_n(wp_n), .req_valid(req_valid),
    .req_op(req_op), .req_idx(req_idx), .qry_idx(qry_idx),
    .qry_state(qry_state), .qry_write_ok(qry_write_ok),
    .read_mode_pulse(read_mode_pulse), .req_err(req_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(input int idx, input string req, input int st, input int wok);
    qry_idx = IW'(idx);
    #1;
    chk(req, int'(qry_state), st);
    chk(req, int'(qry_write_ok), wok);
  endtask

  task automatic issue(input logic [1:0] op, input int idx);
    req_valid = 1'b1;
    req_op    = op;
    req_idx   = IW'(idx);
    tick();
    req_valid = 1'b0;
    req_op    = 2'b00;
  endtask

  task automatic t_reset_hold();
    issue(2'b10, 2);          // ignored in reset
    look(2, "R1", 1, 0);
    look(11, "R1", 1, 0);
    chk("R1", int'(read_mode_pulse), 0);
    rst_pin_n = 1'b1;
    tick();
    chk("R2", int'(read_mode_pulse), 1);
    look(0, "R2", 1, 0);
    tick();
    chk("R2", int'(read_mode_pulse), 0);
  endtask

  task automatic t_lock_unlock();
    issue(2'b10, 3);
    look(3, "R3", 0, 1);
    look(4, "R3", 1, 0);
    issue(2'b00, 3);          // no-op keeps state
    look(3, "R3", 0, 1);
    issue(2'b01, 3);
    look(3, "R8", 1, 0);
  endtask

  task automatic t_lockdown();
    wp_n = 1'b0;
    tick();
    issue(2'b11, 5);
    look(5, "R4", 3, 0);
    issue(2'b10, 5);
    look(5, "R5", 3, 0);
    issue(2'b10, 6);
    look(6, "R5", 0, 1);
  endtask

  task automatic t_wp_high();
    wp_n = 1'b1;
    tick();
    look(5, "R6", 1, 0);
    issue(2'b10, 5);
    look(5, "R6", 0, 1);
    issue(2'b01, 5);
    look(5, "R6", 1, 0);
    issue(2'b10, 5);
    look(5, "R11", 0, 1);
    wp_n = 1'b0;
    tick();
    look(5, "R7", 3, 0);
  endtask

  task automatic t_same_cycle();
    wp_n = 1'b1;
    tick();
    issue(2'b10, 5);
    look(5, "R10", 0, 1);
    wp_n = 1'b0;
    issue(2'b10, 5);          // edge applied before the unlock
    look(5, "R10", 3, 0);
  endtask

  task automatic t_range();
    issue(2'b10, 12);
    chk("R9", int'(req_err), 1);
    look(4, "R9", 1, 0);
    look(0, "R9", 1, 0);
    tick();
    chk("R9", int'(req_err), 0);
    look(13, "R9", 1, 0);
    issue(2'b10, 1);
    chk("R9", int'(req_err), 0);
  endtask

  task automatic t_reset_clears();
    rst_pin_n = 1'b0;
    tick();
    look(5, "R1", 1, 0);
    look(6, "R1", 1, 0);
    rst_pin_n = 1'b1;
    tick();
    chk("R2", int'(read_mode_pulse), 1);
    look(5, "R11", 1, 0);
    issue(2'b10, 5);
    look(5, "R11", 0, 1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_pin_n = 1'b0;
    wp_n      = 1'b1;
    req_valid = 1'b0;
    req_op    = 2'b00;
    req_idx   = '0;
    qry_idx   = '0;
    repeat (4) tick();
    t_reset_hold();
    t_lock_unlock();
    t_lockdown();
    t_wp_high();
    t_same_cycle();
    t_range();
    t_reset_clears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule